// File: doc/BRIEF.md
# Banked Data Address Generator

This block turns the register-file operand of a direct-addressed instruction into a 12-bit data-memory address. The data space is 4 KB, cut into sixteen 256-byte banks, so bank n covers n00h up to nFFh. Each instruction carries an 8-bit file address and a one-bit window select. The select bit chooses one of two ways to form the address.

With the select bit clear, the address lands in a split window. File addresses below 80h reach the bottom 128 bytes of RAM. File addresses from 80h upward reach the special-function register area at F80h–FFFh, where the working register sits at FE8h. With the select bit set, a 4-bit bank number held in an internal bank register supplies the top of the address.

The bank register is 8 bits wide as seen on its write and read ports, but only its low nibble is stored. It clears on reset. A write lands at a clock edge, and instructions use the new bank from the next cycle on. The address path has no registers, so there is no stream and no back-pressure. Fields presented in a cycle produce their address in that same cycle.

Top module: `adg_banked_addr`

## Requirements
- R1: After reset the bank register reads back 00h, and the banked path produces address {0h, file}.
- R2: When bank_wr_en is high at a rising clock edge, the bank register stores bank_wr_data[3:0], and bank_rd shows it after that edge. When bank_wr_en is low, the register holds its value.
- R3: bank_rd[7:4] always reads 0. Any value written to bank_wr_data[7:4] is ignored.
- R4: With bank_sel_en = 0 and file_addr in 00h–7Fh, data_addr = 000h + file_addr.
- R5: With bank_sel_en = 0 and file_addr in 80h–FFh, data_addr = F00h + file_addr, covering F80h–FFFh (file address E8h gives FE8h).
- R6: With bank_sel_en = 1, data_addr = {bank_rd[3:0], file_addr}, with the bank nibble in bits 11:8.
- R7: In the cycle that carries a bank write, the address still uses the old bank. The new bank takes effect from the following cycle.
- R8: With bank_sel_en = 0, data_addr does not depend on the bank register contents.
- R9: data_addr is combinational in file_addr and bank_sel_en, and is valid in the same cycle the fields are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the bank register |
| file_addr | input | 8 | File address field of the instruction |
| bank_sel_en | input | 1 | Window select: 0 = split access window, 1 = banked |
| bank_wr_en | input | 1 | Bank register write strobe |
| bank_wr_data | input | 8 | Bank register write data; only bits 3:0 are kept |
| bank_rd | output | 8 | Bank register read-back; upper nibble always zero |
| data_addr | output | 12 | Resulting data-memory address |

## Verification
The embedded properties watch every cycle for these rules:
- the bank read-back upper nibble stays zero;
- a write lands one edge later, and the register otherwise holds;
- the banked address carries the bank nibble;
- the access window sends low file addresses to page 0 and high ones to page F.

Some behaviour is visible only through the bench's scenarios:
- exact address values across patterns;
- the reset value;
- that the cycle carrying a write still uses the old bank;
- that the access window is unaffected by the bank contents.

// File: rtl/adg_pkg.sv
package adg_pkg;
  localparam int unsigned FILE_W = 8;
  localparam int unsigned BANK_W = 4;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = FILE_W + BANK_W;

  typedef enum logic {
    WIN_ACCESS = 1'b0,
    WIN_BANKED = 1'b1
  } win_sel_e;
endpackage

// File: rtl/adg_bank_reg.sv
module adg_bank_reg #(
  parameter int unsigned REG_W  = adg_pkg::REG_W,
  parameter int unsigned BANK_W = adg_pkg::BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [BANK_W-1:0] bank,
  output logic [REG_W-1:0]  rd_data
);
  localparam int unsigned PAD_W = REG_W - BANK_W;

  logic [BANK_W-1:0] bank_q;

  // only the low nibble is stored; upper bits are never kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank_q <= '0;
    else if (wr_en) bank_q <= wr_data[BANK_W-1:0];
  end

  assign bank    = bank_q;
  assign rd_data = {{PAD_W{1'b0}}, bank_q};

  assert_hi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:BANK_W] == '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[BANK_W-1:0] == $past(wr_data[BANK_W-1:0]));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/adg_access_map.sv
module adg_access_map #(
  parameter int unsigned FILE_W = adg_pkg::FILE_W,
  parameter int unsigned BANK_W = adg_pkg::BANK_W
) (
  input  logic [FILE_W-1:0]        file_addr,
  output logic [FILE_W+BANK_W-1:0] win_addr
);
  // lower half of the file range -> page 0, upper half -> top page
  logic upper_half;
  assign upper_half = file_addr[FILE_W-1];
  assign win_addr   = {{BANK_W{upper_half}}, file_addr};
endmodule

// File: rtl/adg_banked_addr.sv
module adg_banked_addr #(
  parameter int unsigned FILE_W = adg_pkg::FILE_W,
  parameter int unsigned BANK_W = adg_pkg::BANK_W,
  parameter int unsigned REG_W  = adg_pkg::REG_W,
  localparam int unsigned ADDR_W = FILE_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILE_W-1:0] file_addr,
  input  logic              bank_sel_en,
  input  logic              bank_wr_en,
  input  logic [REG_W-1:0]  bank_wr_data,
  output logic [REG_W-1:0]  bank_rd,
  output logic [ADDR_W-1:0] data_addr
);
  import adg_pkg::*;

  logic [BANK_W-1:0] bank_cur;
  logic [ADDR_W-1:0] win_addr;
  logic [ADDR_W-1:0] bnk_addr;
  win_sel_e          sel;

  adg_bank_reg #(.REG_W(REG_W), .BANK_W(BANK_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bank_wr_en),
    .wr_data (bank_wr_data),
    .bank    (bank_cur),
    .rd_data (bank_rd)
  );

  adg_access_map #(.FILE_W(FILE_W), .BANK_W(BANK_W)) u_win (
    .file_addr (file_addr),
    .win_addr  (win_addr)
  );

  assign bnk_addr = {bank_cur, file_addr};
  assign sel      = win_sel_e'(bank_sel_en);

  always_comb begin
    unique case (sel)
      WIN_BANKED: data_addr = bnk_addr;
      default:    data_addr = win_addr;
    endcase
  end

  assert_banked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel_en |-> (data_addr[ADDR_W-1:FILE_W] == bank_rd[BANK_W-1:0]
                     && data_addr[FILE_W-1:0] == file_addr));

  assert_low_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_sel_en && !file_addr[FILE_W-1]) |-> data_addr[ADDR_W-1:FILE_W] == '0);

  assert_high_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_sel_en && file_addr[FILE_W-1]) |-> data_addr[ADDR_W-1:FILE_W] == '1);
endmodule

// File: tb/adg_banked_addr_test.sv
`timescale 1ns/1ps
module adg_banked_addr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  file_addr = '0;
  logic        bank_sel_en = 1'b0;
  logic        bank_wr_en = 1'b0;
  logic [7:0]  bank_wr_data = '0;
  logic [7:0]  bank_rd;
  logic [11:0] data_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adg_banked_addr uut (
    .clk(clk), .rst_n(rst_n), .file_addr(file_addr), .bank_sel_en(bank_sel_en),
    .bank_wr_en(bank_wr_en), .bank_wr_data(bank_wr_data),
    .bank_rd(bank_rd), .data_addr(data_addr)
  );

  // {bank write data, select bit, file address, expected address}
  localparam int NV = 10;
  localparam logic [28:0] VEC [NV] = '{
    {8'h00, 1'b0, 8'h00, 12'h000},   // R4
    {8'h00, 1'b0, 8'h7F, 12'h07F},   // R4
    {8'h00, 1'b0, 8'h80, 12'hF80},   // R5
    {8'h00, 1'b0, 8'hE8, 12'hFE8},   // R5
    {8'h03, 1'b1, 8'h45, 12'h345},   // R6
    {8'h0F, 1'b1, 8'hFF, 12'hFFF},   // R6
    {8'hA7, 1'b1, 8'h10, 12'h710},   // R3 high bits dropped
    {8'h09, 1'b0, 8'h12, 12'h012},   // R8
    {8'h0C, 1'b0, 8'hC3, 12'hFC3},   // R8
    {8'h01, 1'b1, 8'h00, 12'h100}    // R6
  };

  task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %03h expected %03h", req, got, exp);
    end
  endtask

  task automatic wr_bank(input logic [7:0] v);
    @(negedge clk);
    bank_wr_en = 1'b1; bank_wr_data = v;
    @(negedge clk);
    bank_wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bank_sel_en = 1'b1; file_addr = 8'h12; #1;
    chk("R1 bank_rd", {4'h0, bank_rd}, 12'h000);
    chk("R1 addr", data_addr, 12'h012);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr_bank(VEC[i][28:21]);
      bank_sel_en = VEC[i][20]; file_addr = VEC[i][19:12]; #1;
      chk("R2 readback", {4'h0, bank_rd}, {8'h00, VEC[i][24:21]});
      chk("R3 upper zero", {8'h00, bank_rd[7:4]}, 12'h000);
      chk("R4/R5/R6/R8 addr", data_addr, VEC[i][11:0]);
    end

    // R9 same-cycle change of fields without a clock edge
    wr_bank(8'h06);
    bank_sel_en = 1'b1; file_addr = 8'h2A; #1;
    chk("R9 banked", data_addr, 12'h62A);
    bank_sel_en = 1'b0; #1;
    chk("R9 window", data_addr, 12'h02A);
    file_addr = 8'hAA; #1;
    chk("R9 window high", data_addr, 12'hFAA);

    // R7 old bank in the write cycle, new bank after
    @(negedge clk);
    bank_sel_en = 1'b1; file_addr = 8'h33;
    bank_wr_en = 1'b1; bank_wr_data = 8'hF5; #1;
    chk("R7 old bank", data_addr, 12'h633);
    @(negedge clk);
    bank_wr_en = 1'b0; #1;
    chk("R7 new bank", data_addr, 12'h533);
    chk("R3 write F5", {4'h0, bank_rd}, 12'h005);

    // R2 hold with no strobe
    bank_wr_data = 8'h0E;
    repeat (3) @(negedge clk);
    #1;
    chk("R2 hold", {4'h0, bank_rd}, 12'h005);

    // R1 reset clears a nonzero bank
    rst_n = 1'b0; #1;
    chk("R1 async clear", {4'h0, bank_rd}, 12'h000);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 addr after reset", data_addr, 12'h033);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule